// File: doc/BRIEF.md
# In-Place Fixed-Point FFT Engine

This block computes an N-point complex FFT in place on its own buffer of N complex Q15 words. N is a compile-time power of two from 8 to 1024. While the engine is idle, an external loader fills the buffer through a write port. Each input sample must go to the address whose index bits are the reverse of the sample's time index. A start pulse then runs every stage. When the last stage finishes, a one-cycle done pulse is raised, and the spectrum can be read in natural bin order through a registered read port.

The first two decimation-in-time stages are fused into one radix-4 pass. That pass uses no multiplier and scales its results by 1/4. The third stage uses four hard-wired twiddles. Every later stage uses a generic radix-2 butterfly that scales its results by 1/2. The twiddles for these later stages come from an external combinational cosine/sine lookup. The overall 1/N scaling is therefore spread evenly over the stages.

Top module: `fft_inplace`

## Requirements
- R1: While busy is low and ld_we is high, {ld_re, ld_im} is written to buffer entry ld_addr at the clock edge. A write offered while busy is high leaves the buffer unchanged.
- R2: A start pulse while idle raises busy on the next cycle. A start pulse while busy is ignored and does not restart or lengthen the run.
- R3: A run lasts exactly N/4 + (log2(N)-2)·N/2 cycles of busy. After that, busy falls, and done is high for exactly one cycle, the first cycle in which busy is low.
- R4: The first pass takes each group of four consecutive entries x0..x3 and forms a=x0+x1, b=x0-x1, c=x2+x3, d=x2-x3. It writes back x0=a+c, x1=(br+di, bi-dr), x2=a-c and x3=(br-di, bi+dr). Each part is rounded as (v+2)>>>2.
- R5: In the third stage, butterfly k has index j=k mod 4, and its dual-node product T (in Q30) is chosen by j:
  - j=0: Q·2^15.
  - j=1: C·(Qr+Qi) for the real part and C·(Qi-Qr) for the imaginary part.
  - j=2: Qi·2^15 for the real part and -Qr·2^15 for the imaginary part.
  - j=3: C·(Qi-Qr) for the real part and -C·(Qr+Qi) for the imaginary part.
  - Here C=23170.
- R6: In stage s≥4, butterfly k has half=2^(s-1), j=k mod half, primary address p=2·half·floor(k/half)+j and dual address p+half.
  - The block presents tw_addr=j·2^(log2N-s) and uses tw_cos and tw_sin in the same cycle.
  - The product is Tr=Qr·cos+Qi·sin and Ti=Qi·cos-Qr·sin.
- R7: In every stage from the third on, each butterfly output is floor((P·2^15 ± T + 2^15)/2^16). The new primary takes the plus sign and the new dual takes the minus sign.
- R8: Every value written back by R4 or R7 is saturated to the range -32768..32767.
- R9: After done, rd_re and rd_im show bin rd_addr one cycle after rd_addr is presented. The bins are in natural order when the input was loaded bit-reversed.
- R10: During reset and after it, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_we | input | 1 | Load write enable |
| ld_addr | input | log2(N) | Load address |
| ld_re | input | 16 | Load real part, Q15 |
| ld_im | input | 16 | Load imaginary part, Q15 |
| rd_addr | input | log2(N) | Result read address |
| rd_re | output | 16 | Result real part, one cycle latency |
| rd_im | output | 16 | Result imaginary part, one cycle latency |
| tw_addr | output | log2(N)-1 | Twiddle index r of e^(-j2πr/N) |
| tw_cos | input | 16 | cos(2πr/N), Q15 |
| tw_sin | input | 16 | sin(2πr/N), Q15 |

## Verification
The bench builds the block with N=16, so a single run covers the fused radix-4 pass, the special third stage and one generic stage, the fourth. The fourth stage takes its twiddles from the lookup port, so the tw_addr formula and the sign conventions of the generic product are checked against the bench's own cosine table. The small size keeps each run at 20 cycles, which leaves room for many full-spectrum comparisons. These cover an impulse, a DC input, a single-bin tone, a saturating full-scale pattern and random vectors. A start pulse and a load write are both injected in the middle of a run.

// File: rtl/fft_inplace.sv
module fft_inplace #(
  parameter int N = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  output logic                      busy,
  output logic                      done,
  input  logic                      ld_we,
  input  logic [$clog2(N)-1:0]      ld_addr,
  input  logic signed [15:0]        ld_re,
  input  logic signed [15:0]        ld_im,
  input  logic [$clog2(N)-1:0]      rd_addr,
  output logic signed [15:0]        rd_re,
  output logic signed [15:0]        rd_im,
  output logic [$clog2(N)-2:0]      tw_addr,
  input  logic signed [15:0]        tw_cos,
  input  logic signed [15:0]        tw_sin
);
  localparam int LG = $clog2(N);
  localparam logic signed [33:0] C707 = 34'sd23170;
  localparam logic [LG-2:0] LAST_QUAD = (LG-1)'(N/4 - 1);
  localparam logic [LG-2:0] LAST_BF   = (LG-1)'(N/2 - 1);

  typedef enum logic [1:0] {IDLE, QUAD, BFLY} state_t;
  state_t state;
  logic [4:0]    stg;
  logic [LG-2:0] k;
  logic signed [15:0] mre [N];
  logic signed [15:0] mim [N];

  assign busy = (state != IDLE);

  function automatic logic signed [15:0] sat16(input logic signed [35:0] v);
    if (v > 36'sd32767)       return 16'sh7fff;
    else if (v < -36'sd32768) return 16'sh8000;
    else                      return v[15:0];
  endfunction

  function automatic logic signed [15:0] quarter(input logic signed [17:0] v);
    return sat16((36'(v) + 36'sd2) >>> 2);
  endfunction

  function automatic logic signed [15:0] half_out(input logic signed [15:0] p,
                                                  input logic signed [33:0] t,
                                                  input logic neg);
    logic signed [35:0] s;
    s = (36'(p) <<< 15) + (neg ? -36'(t) : 36'(t)) + 36'sd32768;
    return sat16(s >>> 16);
  endfunction

  // radix-4 block addressing
  logic [LG-1:0] base;
  assign base = {k[LG-3:0], 2'b00};
  logic signed [15:0] x0r, x0i, x1r, x1i, x2r, x2i, x3r, x3i;
  assign x0r = mre[base];      assign x0i = mim[base];
  assign x1r = mre[base | 1];  assign x1i = mim[base | 1];
  assign x2r = mre[base | 2];  assign x2i = mim[base | 2];
  assign x3r = mre[base | 3];  assign x3i = mim[base | 3];

  logic signed [17:0] ar, ai, br, bi, cr, ci, dr, di;
  assign ar = 18'(x0r) + 18'(x1r);  assign ai = 18'(x0i) + 18'(x1i);
  assign br = 18'(x0r) - 18'(x1r);  assign bi = 18'(x0i) - 18'(x1i);
  assign cr = 18'(x2r) + 18'(x3r);  assign ci = 18'(x2i) + 18'(x3i);
  assign dr = 18'(x2r) - 18'(x3r);  assign di = 18'(x2i) - 18'(x3i);

  // radix-2 butterfly addressing
  logic [LG-1:0] hspan, kx, jx, pa, qa, twx;
  assign hspan = LG'(1) << (stg - 5'd1);
  assign kx    = {1'b0, k};
  assign jx    = kx & (hspan - LG'(1));
  assign pa    = ((kx & ~(hspan - LG'(1))) << 1) | jx;
  assign qa    = pa | hspan;
  assign twx   = jx << (5'(LG) - stg);
  assign tw_addr = twx[LG-2:0];

  logic signed [15:0] pr, pi, qr, qi;
  assign pr = mre[pa];  assign pi = mim[pa];
  assign qr = mre[qa];  assign qi = mim[qa];

  logic signed [16:0] qsum, qdif;
  assign qsum = 17'(qr) + 17'(qi);
  assign qdif = 17'(qi) - 17'(qr);

  logic signed [33:0] tr, ti;
  always_comb begin
    if (stg == 5'd3) begin
      unique case (k[1:0])
        2'd0: begin tr = 34'(qr) <<< 15;  ti = 34'(qi) <<< 15; end
        2'd1: begin tr = C707 * 34'(qsum); ti = C707 * 34'(qdif); end
        2'd2: begin tr = 34'(qi) <<< 15;  ti = -(34'(qr) <<< 15); end
        default: begin tr = C707 * 34'(qdif); ti = -(C707 * 34'(qsum)); end
      endcase
    end else begin
      tr = 34'(qr) * 34'(tw_cos) + 34'(qi) * 34'(tw_sin);
      ti = 34'(qi) * 34'(tw_cos) - 34'(qr) * 34'(tw_sin);
    end
  end

  always_ff @(posedge clk) begin
    rd_re <= mre[rd_addr];
    rd_im <= mim[rd_addr];
    if (!rst_n) begin
      state <= IDLE;
      done  <= 1'b0;
      k     <= '0;
      stg   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        IDLE: begin
          if (ld_we) begin
            mre[ld_addr] <= ld_re;
            mim[ld_addr] <= ld_im;
          end
          if (start) begin
            state <= QUAD;
            k     <= '0;
          end
        end
        QUAD: begin
          mre[base]     <= quarter(ar + cr);
          mim[base]     <= quarter(ai + ci);
          mre[base | 1] <= quarter(br + di);
          mim[base | 1] <= quarter(bi - dr);
          mre[base | 2] <= quarter(ar - cr);
          mim[base | 2] <= quarter(ai - ci);
          mre[base | 3] <= quarter(br - di);
          mim[base | 3] <= quarter(bi + dr);
          if (k == LAST_QUAD) begin
            k     <= '0;
            stg   <= 5'd3;
            state <= BFLY;
          end else k <= k + 1'b1;
        end
        default: begin
          mre[pa] <= half_out(pr, tr, 1'b0);
          mim[pa] <= half_out(pi, ti, 1'b0);
          mre[qa] <= half_out(pr, tr, 1'b1);
          mim[qa] <= half_out(pi, ti, 1'b1);
          if (k == LAST_BF) begin
            k <= '0;
            if (stg == 5'(LG)) begin
              state <= IDLE;
              done  <= 1'b1;
            end else stg <= stg + 5'd1;
          end else k <= k + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/fft_inplace_chk.sv
module fft_inplace_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R3
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R3
  AST_START_BEGINS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R2
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done)); // R10
endmodule

bind fft_inplace fft_inplace_chk chk_i (.*);

// File: tb/fft_inplace_tb_top.sv
`timescale 1ns/1ps
module fft_inplace_tb_top;
  localparam int N  = 16;
  localparam int LG = 4;
  localparam int RUN_CYC = N/4 + (LG-2)*N/2;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, ld_we = 0;
  logic [LG-1:0] ld_addr = '0, rd_addr = '0;
  logic signed [15:0] ld_re = 0, ld_im = 0;
  logic busy, done;
  logic signed [15:0] rd_re, rd_im, tw_cos, tw_sin;
  logic [LG-2:0] tw_addr;
  logic signed [15:0] tcos [N/2];
  logic signed [15:0] tsin [N/2];

  always #4 clk = ~clk;

  assign tw_cos = tcos[tw_addr];
  assign tw_sin = tsin[tw_addr];

  fft_inplace #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_re(ld_re), .ld_im(ld_im),
    .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im),
    .tw_addr(tw_addr), .tw_cos(tw_cos), .tw_sin(tw_sin));

  int tests = 0, fails = 0;
  int in_re [N], in_im [N], ex_re [N], ex_im [N];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int brev(input int a);
    int r = 0;
    for (int i = 0; i < LG; i++) if (a[i]) r |= 1 << (LG-1-i);
    return r;
  endfunction

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint hb(input longint p, input longint t, input bit neg);
    return sat(((p * 32768) + (neg ? -t : t) + 32768) >>> 16);
  endfunction

  function automatic longint q4(input longint v);
    return sat((v + 2) >>> 2);
  endfunction

  task automatic model();
    longint xr [N], xi [N];
    for (int a = 0; a < N; a++) begin xr[a] = in_re[brev(a)]; xi[a] = in_im[brev(a)]; end
    for (int b = 0; b < N; b += 4) begin
      longint ar, ai, br, bi, cr, ci, dr, di;
      ar = xr[b] + xr[b+1]; ai = xi[b] + xi[b+1];
      br = xr[b] - xr[b+1]; bi = xi[b] - xi[b+1];
      cr = xr[b+2] + xr[b+3]; ci = xi[b+2] + xi[b+3];
      dr = xr[b+2] - xr[b+3]; di = xi[b+2] - xi[b+3];
      xr[b] = q4(ar + cr);   xi[b] = q4(ai + ci);
      xr[b+1] = q4(br + di); xi[b+1] = q4(bi - dr);
      xr[b+2] = q4(ar - cr); xi[b+2] = q4(ai - ci);
      xr[b+3] = q4(br - di); xi[b+3] = q4(bi + dr);
    end
    for (int s = 3; s <= LG; s++) begin
      int h = 1 << (s-1);
      for (int k = 0; k < N/2; k++) begin
        int j = k % h;
        int p = (k / h) * 2 * h + j;
        int q = p + h;
        longint tr, ti, sm, df, pr, pi;
        sm = xr[q] + xi[q]; df = xi[q] - xr[q];
        if (s == 3) begin
          case (j)
            0: begin tr = xr[q] * 32768; ti = xi[q] * 32768; end
            1: begin tr = 23170 * sm; ti = 23170 * df; end
            2: begin tr = xi[q] * 32768; ti = -xr[q] * 32768; end
            default: begin tr = 23170 * df; ti = -23170 * sm; end
          endcase
        end else begin
          int r = j << (LG - s);
          tr = xr[q] * tcos[r] + xi[q] * tsin[r];
          ti = xi[q] * tcos[r] - xr[q] * tsin[r];
        end
        pr = xr[p]; pi = xi[p];
        xr[p] = hb(pr, tr, 0); xi[p] = hb(pi, ti, 0);
        xr[q] = hb(pr, tr, 1); xi[q] = hb(pi, ti, 1);
      end
    end
    for (int a = 0; a < N; a++) begin ex_re[a] = int'(xr[a]); ex_im[a] = int'(xi[a]); end
  endtask

  task automatic load_all();
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      ld_we = 1; ld_addr = LG'(brev(n));
      ld_re = 16'(in_re[n]); ld_im = 16'(in_im[n]);
    end
    @(negedge clk); ld_we = 0;
  endtask

  task automatic run(input string name, input bit meddle);
    int cyc = 0;
    model();
    load_all();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R2", {name, " busy after start"}, busy, 1);
    while (!done && cyc < 1000) begin
      if (meddle && cyc == 5) begin
        start = 1; ld_we = 1; ld_addr = 0; ld_re = 16'sh1234; ld_im = -16'sd77;
      end else begin
        start = 0; ld_we = 0;
      end
      @(negedge clk); cyc++;
    end
    start = 0; ld_we = 0;
    chk("R3", {name, " run length"}, cyc, RUN_CYC);
    chk("R3", {name, " busy low at done"}, busy, 0);
    @(negedge clk);
    chk("R3", {name, " done single cycle"}, done, 0);
    chk("R2", {name, " no restart"}, busy, 0);
    for (int a = 0; a < N; a++) begin
      rd_addr = LG'(a);
      @(negedge clk);
      chk(meddle ? "R1" : "R9", $sformatf("%s bin %0d re", name, a), rd_re, ex_re[a]);
      chk(meddle ? "R1" : "R9", $sformatf("%s bin %0d im", name, a), rd_im, ex_im[a]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < N/2; r++) begin
      tcos[r] = 16'($rtoi($floor(32767.0 * $cos(6.283185307179586 * r / N) + 0.5)));
      tsin[r] = 16'($rtoi($floor(32767.0 * $sin(6.283185307179586 * r / N) + 0.5)));
    end
    repeat (3) @(negedge clk);
    chk("R10", "busy in reset", busy, 0);
    chk("R10", "done in reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "busy after reset", busy, 0);
    chk("R10", "done after reset", done, 0);

    // impulse: R4 R5 R6 R7 via output match
    for (int n = 0; n < N; n++) begin in_re[n] = 0; in_im[n] = 0; end
    in_re[0] = 20000;
    run("impulse R4", 0);
    // DC
    for (int n = 0; n < N; n++) begin in_re[n] = 12000; in_im[n] = -3000; end
    run("dc R5", 0);
    // single-bin tone at bin 3
    for (int n = 0; n < N; n++) begin
      in_re[n] = $rtoi($floor(16000.0 * $cos(6.283185307179586 * 3 * n / N) + 0.5));
      in_im[n] = $rtoi($floor(16000.0 * $sin(6.283185307179586 * 3 * n / N) + 0.5));
    end
    run("tone R6", 0);
    // full-scale pattern forcing a saturated first-pass value (R8)
    for (int n = 0; n < N; n++) begin in_re[n] = 0; in_im[n] = 0; end
    in_re[0] = 32767; in_re[8] = 32767; in_re[4] = -32768; in_re[12] = -32768;
    in_im[2] = -32768; in_im[10] = -32768; in_im[6] = 32767; in_im[14] = 32767;
    run("saturate R8", 0);
    // random vectors, R7
    void'($urandom(32'd1234));
    for (int t = 0; t < 6; t++) begin
      for (int n = 0; n < N; n++) begin
        if (t == 5) begin
          in_re[n] = ($urandom % 2) ? 32767 : -32768;
          in_im[n] = ($urandom % 2) ? 32767 : -32768;
        end else begin
          in_re[n] = int'($urandom % 65536) - 32768;
          in_im[n] = int'($urandom % 65536) - 32768;
        end
      end
      run($sformatf("random%0d R7", t), 0);
    end
    // start and load injected mid-run must be ignored (R1, R2)
    for (int n = 0; n < N; n++) begin
      in_re[n] = int'($urandom % 20000) - 10000;
      in_im[n] = int'($urandom % 20000) - 10000;
    end
    run("meddle R1 R2", 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule